// File: doc/BRIEF.md
# Translating Misaligned Access Sequencer

This block sits between a processor-side access port and a 32-bit big-endian memory port. On each accepted request it first passes the address through an optional fixed remap, chosen by a two-bit mode register. It then breaks the byte, word or long access into the fewest naturally aligned memory transactions. The beat pattern depends only on the access size and the low two address bits.

Beats go out one at a time over a request/acknowledge handshake. For a write, each beat carries its slice of the write data. For a read, each returned slice is placed in its big-endian lane of a result register. A one-cycle done pulse marks the end of the access. Word results are right-justified in bits 15:0 and byte results in bits 7:0, with the unused upper bits zero.

Top module: `misalign_xlat_seq`

## Requirements
- R1: The mode register is 0 after reset. Writing it with `mode_wr` takes effect for requests accepted from the next cycle. Mode values 0, 1 and 3 send the request address to memory unchanged.
- R2: In mode 2, an address whose low 24 bits fall in 0xA00000..0xDFFFFF becomes those 24 bits ORed with 0x40000000.
- R3: In mode 2, an address whose low 24 bits fall in 0xE00000..0xEFFFFF becomes its low 20 bits ORed with 0xFE000000.
- R4: In mode 2, an address whose low 24 bits are 0xF00000 or above becomes those 24 bits ORed with 0x50000000.
- R5: In mode 2, an address whose low 24 bits are below 0xA00000 keeps only its low 24 bits; bits 31:24 are cleared.
- R6: A long access (size code 2) at a translated address with bits 1:0 = 0 is a single dword beat (memory size code 2) at that address.
- R7: A long access at a translated address with bits 1:0 = 2 is two word beats (memory size code 1): bits 31:16 at the address, then bits 15:0 at address+2.
- R8: A long access at an odd translated address is three beats: a byte (size code 0) holding bits 31:24 at the address, a word holding bits 23:8 at address+1, and a byte holding bits 7:0 at address+3.
- R9: A word access (size code 1) at an even address is one word beat. At an odd address it is two byte beats: bits 15:8 at the address, then bits 7:0 at address+1.
- R10: A byte access (size code 0, and the unused code 3) is one byte beat at the translated address.
- R11: Beats are issued in increasing address order. A beat stays on the memory port unchanged until it is acknowledged, and the next beat appears only after that acknowledge. Beat data is right-justified on `mem_wdata` and `mem_rdata`.
- R12: `done` is high for exactly one cycle, in the cycle after the last acknowledge. For reads, `rdata` then holds the big-endian assembly of the beats and stays stable until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Load `mode_in` into the translation mode register |
| mode_in | input | 2 | New translation mode |
| req_valid | input | 1 | Access request; accepted when `busy` is low |
| req_addr | input | 32 | Logical byte address |
| req_size | input | 2 | 0 byte, 1 word, 2 long |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Right-justified write data |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled, right-justified read result |
| mem_req | output | 1 | Memory beat request |
| mem_addr | output | 32 | Physical beat address |
| mem_size | output | 2 | Beat size: 0 byte, 1 word, 2 dword |
| mem_write | output | 1 | Beat is a write |
| mem_wdata | output | 32 | Right-justified beat write data |
| mem_ack | input | 1 | Beat acknowledge |
| mem_rdata | input | 32 | Right-justified beat read data, valid with `mem_ack` |

## Verification
The assertions assume that `mem_ack` is raised only while `mem_req` is high. They also assume that the translated base address plus three does not wrap past the top of the 32-bit space, because the ascending-address check compares raw addresses. The bench's memory responder raises acknowledge only after it has seen a request, and holds it for one cycle. Random addresses near 0xFFFFFFFF are pulled down whenever translation leaves the upper bits in place.

// File: rtl/mxs_pkg.sv
package mxs_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  localparam logic [1:0] MODE_OFF   = 2'd0;
  localparam logic [1:0] MODE_FIXED = 2'd1;
  localparam logic [1:0] MODE_REMAP = 2'd2;

  typedef struct packed {
    logic [1:0] off;
    logic [1:0] size;
    logic [4:0] shift;
  } beat_t;

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_LONG: size_mask = 32'hFFFF_FFFF;
      SZ_WORD: size_mask = 32'h0000_FFFF;
      default: size_mask = 32'h0000_00FF;
    endcase
  endfunction

  function automatic logic [31:0] wr_lane(input logic [31:0] wd, input logic [1:0] sz,
                                          input logic [4:0] sh);
    wr_lane = (wd >> sh) & size_mask(sz);
  endfunction

  function automatic logic [31:0] rd_lane(input logic [31:0] rd, input logic [1:0] sz,
                                          input logic [4:0] sh);
    rd_lane = (rd & size_mask(sz)) << sh;
  endfunction
endpackage

// File: rtl/mxs_addr_remap.sv
module mxs_addr_remap
  import mxs_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          KEEP_W   = 24,
  parameter int          NARROW_W = 20,
  parameter logic [31:0] HI_LO    = 32'h00A0_0000,
  parameter logic [31:0] HI_TOP   = 32'h00DF_FFFF,
  parameter logic [31:0] NR_LO    = 32'h00E0_0000,
  parameter logic [31:0] NR_TOP   = 32'h00EF_FFFF,
  parameter logic [31:0] TOP_LO   = 32'h00F0_0000,
  parameter logic [31:0] HI_SET   = 32'h4000_0000,
  parameter logic [31:0] NR_SET   = 32'hFE00_0000,
  parameter logic [31:0] TOP_SET  = 32'h5000_0000
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam logic [ADDR_W-1:0] KEEP_MASK   = ADDR_W'((64'd1 << KEEP_W) - 1);
  localparam logic [ADDR_W-1:0] NARROW_MASK = ADDR_W'((64'd1 << NARROW_W) - 1);

  logic [ADDR_W-1:0] kept;

  always_comb begin
    kept     = addr_in & KEEP_MASK;
    addr_out = addr_in;
    if (mode == MODE_REMAP) begin
      if (kept >= ADDR_W'(HI_LO) && kept <= ADDR_W'(HI_TOP))
        addr_out = kept | ADDR_W'(HI_SET);
      else if (kept >= ADDR_W'(NR_LO) && kept <= ADDR_W'(NR_TOP))
        addr_out = (kept & NARROW_MASK) | ADDR_W'(NR_SET);
      else if (kept >= ADDR_W'(TOP_LO))
        addr_out = kept | ADDR_W'(TOP_SET);
      else
        addr_out = kept;
    end
  end
endmodule

// File: rtl/mxs_beat_plan.sv
module mxs_beat_plan
  import mxs_pkg::*;
(
  input  logic [1:0] size,
  input  logic [1:0] align,
  input  logic [1:0] idx,
  output beat_t      beat,
  output logic       last
);
  logic [1:0] nb_m1;

  always_comb begin
    beat  = '{off: 2'd0, size: SZ_BYTE, shift: 5'd0};
    nb_m1 = 2'd0;
    case (size)
      SZ_LONG: begin
        if (align == 2'd0) begin
          beat.size = SZ_LONG;
        end else if (!align[0]) begin
          nb_m1     = 2'd1;
          beat.size = SZ_WORD;
          if (idx == 2'd0) beat.shift = 5'd16;
          else             beat.off   = 2'd2;
        end else begin
          nb_m1 = 2'd2;
          case (idx)
            2'd0:    beat.shift = 5'd24;
            2'd1:    begin beat.off = 2'd1; beat.size = SZ_WORD; beat.shift = 5'd8; end
            default: beat.off = 2'd3;
          endcase
        end
      end
      SZ_WORD: begin
        if (!align[0]) begin
          beat.size = SZ_WORD;
        end else begin
          nb_m1 = 2'd1;
          if (idx == 2'd0) beat.shift = 5'd8;
          else             beat.off   = 2'd1;
        end
      end
      default: ;
    endcase
    last = (idx == nb_m1);
  end
endmodule

// File: rtl/misalign_xlat_seq.sv
module misalign_xlat_seq
  import mxs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [1:0]        mode_in,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic              mem_write,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W = 2;

  logic [1:0]        mode_q;
  logic              active;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        size_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] acc_q;
  logic [1:0]        cur_size;
  logic [4:0]        cur_shift;
  logic              cur_last;

  logic              accept, beat_ack;
  logic [ADDR_W-1:0] xaddr;
  logic [ADDR_W-1:0] plan_base;
  logic [1:0]        plan_sz;
  logic [IDX_W-1:0]  plan_idx;
  logic [DATA_W-1:0] plan_wd;
  beat_t             plan;
  logic              plan_last;
  logic [DATA_W-1:0] lane_in;

  assign accept   = req_valid && !active;
  assign beat_ack = active && mem_req && mem_ack;
  assign busy     = active;

  mxs_addr_remap #(.ADDR_W(ADDR_W)) u_remap (
    .mode     (mode_q),
    .addr_in  (req_addr),
    .addr_out (xaddr)
  );

  always_comb begin
    if (accept) begin
      plan_base = xaddr;
      plan_sz   = req_size;
      plan_idx  = '0;
      plan_wd   = req_wdata;
    end else begin
      plan_base = base_q;
      plan_sz   = size_q;
      plan_idx  = idx_q + IDX_W'(1);
      plan_wd   = wdata_q;
    end
  end

  mxs_beat_plan u_plan (
    .size  (plan_sz),
    .align (plan_base[1:0]),
    .idx   (plan_idx),
    .beat  (plan),
    .last  (plan_last)
  );

  assign lane_in = rd_lane(mem_rdata, cur_size, cur_shift);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_OFF;
      active    <= 1'b0;
      base_q    <= '0;
      size_q    <= SZ_BYTE;
      write_q   <= 1'b0;
      wdata_q   <= '0;
      idx_q     <= '0;
      acc_q     <= '0;
      cur_size  <= SZ_BYTE;
      cur_shift <= '0;
      cur_last  <= 1'b0;
      done      <= 1'b0;
      rdata     <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      mem_size  <= SZ_BYTE;
      mem_write <= 1'b0;
      mem_wdata <= '0;
    end else begin
      done <= 1'b0;
      if (mode_wr) mode_q <= mode_in;
      if (accept) begin
        active    <= 1'b1;
        base_q    <= xaddr;
        size_q    <= req_size;
        write_q   <= req_write;
        wdata_q   <= req_wdata;
        idx_q     <= '0;
        acc_q     <= '0;
        mem_req   <= 1'b1;
        mem_addr  <= xaddr + ADDR_W'(plan.off);
        mem_size  <= plan.size;
        mem_write <= req_write;
        mem_wdata <= wr_lane(plan_wd, plan.size, plan.shift);
        cur_size  <= plan.size;
        cur_shift <= plan.shift;
        cur_last  <= plan_last;
      end else if (beat_ack) begin
        if (cur_last) begin
          active  <= 1'b0;
          mem_req <= 1'b0;
          done    <= 1'b1;
          if (!write_q) rdata <= acc_q | lane_in;
        end else begin
          idx_q     <= plan_idx;
          acc_q     <= acc_q | lane_in;
          mem_addr  <= base_q + ADDR_W'(plan.off);
          mem_size  <= plan.size;
          mem_wdata <= wr_lane(plan_wd, plan.size, plan.shift);
          cur_size  <= plan.size;
          cur_shift <= plan.shift;
          cur_last  <= plan_last;
        end
      end
    end
  end

  // R11: an unacknowledged beat holds still
  p_beat_hold_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_size)
                            && $stable(mem_write) && $stable(mem_wdata));

  // R11: a following beat of the same access sits at a higher address
  p_ascending_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req && $past(mem_req && mem_ack) |-> mem_addr > $past(mem_addr));

  // R6: dword beats are 4-aligned
  p_dword_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_size == SZ_LONG |-> mem_addr[1:0] == 2'd0);

  // R9: word beats are 2-aligned
  p_word_aligned_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_size == SZ_WORD |-> !mem_addr[0]);

  // R12: done lasts one cycle and follows an acknowledge
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_ack_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(mem_req && mem_ack));

  // R12: result stays put in the cycle after done
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(rdata));
endmodule

// File: tb/misalign_xlat_seq_test.sv
module misalign_xlat_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_wr = 1'b0;
  logic [1:0]  mode_in = 2'd0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        busy, done;
  logic [31:0] rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic        mem_write;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int compared = 0;
  int mismatched = 0;
  logic [1:0] cur_mode = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  misalign_xlat_seq uut (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_in(mode_in),
    .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .req_write(req_write), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_write(mem_write), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] xl(input logic [1:0] m, input logic [31:0] a);
    logic [31:0] t;
    if (m != 2'd2) return a;
    t = {8'h00, a[23:0]};
    if (t >= 32'hA00000 && t <= 32'hDFFFFF) return t | 32'h4000_0000;
    if (t >= 32'hE00000 && t <= 32'hEFFFFF) return {12'h000, t[19:0]} | 32'hFE00_0000;
    if (t >= 32'hF00000) return t | 32'h5000_0000;
    return t;
  endfunction

  function automatic logic [7:0] bv(input logic [31:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ a[31:24] ^ 8'hA5;
  endfunction

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd2) ? 4 : (s == 2'd1) ? 2 : 1;
  endfunction

  function automatic logic [1:0] len_code(input int len);
    return (len == 4) ? 2'd2 : (len == 2) ? 2'd1 : 2'd0;
  endfunction

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode_wr = 1'b1; mode_in = m;
    @(negedge clk);
    mode_wr = 1'b0;
    cur_mode = m;
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] s, input logic wr,
                        input logic [31:0] wd, input string tag);
    logic [31:0] p, exp_r, bd, rd_before;
    int n, nb, lens[3], offs[3];
    n = nbytes(s);
    p = xl(cur_mode, a);
    nb = 1; offs[0] = 0; lens[0] = n;
    if (s == 2'd2 && p[1:0] == 2'd2) begin
      nb = 2; offs[0] = 0; lens[0] = 2; offs[1] = 2; lens[1] = 2;
    end else if (s == 2'd2 && p[0]) begin
      nb = 3; offs[0] = 0; lens[0] = 1; offs[1] = 1; lens[1] = 2; offs[2] = 3; lens[2] = 1;
    end else if (s == 2'd1 && p[0]) begin
      nb = 2; offs[0] = 0; lens[0] = 1; offs[1] = 1; lens[1] = 1;
    end
    exp_r = '0;
    for (int k = 0; k < n; k++) exp_r = (exp_r << 8) | {24'h0, bv(p + k)};
    rd_before = rdata;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = s; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int b = 0; b < nb; b++) begin
      int t, dly;
      logic [31:0] a0;
      t = 0;
      while (!mem_req && t < 20) begin @(negedge clk); t++; end
      chk({tag, " R11 beat request"}, {31'h0, mem_req}, 32'h1);
      chk({tag, " beat address"}, mem_addr, p + offs[b]);
      chk({tag, " beat size"}, {30'h0, mem_size}, {30'h0, len_code(lens[b])});
      chk({tag, " beat direction"}, {31'h0, mem_write}, {31'h0, wr});
      if (wr) begin
        bd = (wd >> (8 * (n - offs[b] - lens[b]))) &
             ((lens[b] == 4) ? 32'hFFFF_FFFF : (lens[b] == 2) ? 32'hFFFF : 32'hFF);
        chk({tag, " beat write data"}, mem_wdata, bd);
      end
      a0 = mem_addr;
      dly = $urandom_range(0, 2);
      if (dly > 0) begin
        repeat (dly) @(negedge clk);
        chk({tag, " R11 held while waiting"}, mem_addr, a0);
      end
      bd = '0;
      for (int k = 0; k < lens[b]; k++) bd = (bd << 8) | {24'h0, bv(mem_addr + k)};
      mem_ack = 1'b1; mem_rdata = bd | ~((lens[b] == 4) ? 32'hFFFF_FFFF :
                                         (lens[b] == 2) ? 32'hFFFF : 32'hFF);
      @(negedge clk);
      mem_ack = 1'b0; mem_rdata = '0;
    end
    chk({tag, " R12 done after last ack"}, {31'h0, done}, 32'h1);
    chk({tag, " R11 no extra beat"}, {31'h0, mem_req}, 32'h0);
    chk({tag, " R12 result"}, rdata, wr ? rd_before : exp_r);
    @(negedge clk);
    chk({tag, " R12 done one cycle"}, {31'h0, done}, 32'h0);
    chk({tag, " R12 result held"}, rdata, wr ? rd_before : exp_r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset done", {31'h0, done}, 32'h0);
    chk("R1 reset mem_req", {31'h0, mem_req}, 32'h0);
    chk("R1 reset busy", {31'h0, busy}, 32'h0);
    chk("R12 reset rdata", rdata, 32'h0);

    access(32'h12A0_0010, 2'd2, 1'b0, 0, "R1 default mode passthrough");
    set_mode(2'd1);
    access(32'h00E1_2345, 2'd1, 1'b0, 0, "R1 mode1 passthrough R9");
    set_mode(2'd3);
    access(32'h33F0_0002, 2'd2, 1'b0, 0, "R1 mode3 passthrough R7");
    set_mode(2'd2);
    access(32'h00A0_0000, 2'd2, 1'b0, 0, "R2 low edge R6");
    access(32'hFFDF_FFFC, 2'd2, 1'b0, 0, "R2 high edge");
    access(32'h00E0_0000, 2'd1, 1'b0, 0, "R3 low edge");
    access(32'h77EF_FFFE, 2'd1, 1'b0, 0, "R3 high edge");
    access(32'h00F0_0000, 2'd0, 1'b0, 0, "R4 low edge R10");
    access(32'h12FF_FFFC, 2'd2, 1'b1, 32'hCAFEF00D, "R4 top R6 write");
    access(32'h9B9F_FFFF, 2'd0, 1'b0, 0, "R5 below window");
    access(32'h0012_3401, 2'd2, 1'b0, 0, "R5 R8 odd long read");
    access(32'h0012_3403, 2'd2, 1'b1, 32'h11223344, "R8 odd long write");
    access(32'h0012_3402, 2'd2, 1'b1, 32'hA1B2C3D4, "R7 half long write");
    access(32'h0012_3405, 2'd1, 1'b1, 32'h0000BEEF, "R9 odd word write");
    access(32'h0012_3406, 2'd3, 1'b0, 0, "R10 reserved size");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [1:0] s;
      if ((i % 50) == 0) set_mode(2'($urandom_range(0, 3)));
      a = $urandom;
      if (cur_mode == 2'd2 && (i % 3) == 0) a[23:20] = 4'($urandom_range(8, 15));
      if (cur_mode != 2'd2 && a > 32'hFFFF_FFF0) a = a - 32'h100;
      s = 2'($urandom_range(0, 2));
      access(a, s, 1'($urandom_range(0, 1)), $urandom, "random R2 R3 R4 R6 R7 R8 R9 R10");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule